// File: doc/BRIEF.md
# SDRAM Read-to-Write Turnaround Scheduler

This block issues column commands to one already-open SDRAM row on behalf of a memory controller. Column requests enter on a valid/ready handshake, each either a read or a write carrying bank, column and write data. Each request becomes a registered command in the cycle after it is accepted: READ, WRITE or NOP, with bank and column. The block also drives the data-mask line (DQM), the controller's data output enable, and the write data word. Reads can be issued on every clock. The memory returns each read's word after the programmed CAS latency. The block captures that word and hands it back with its bank and column, in issue order.

When a write follows reads, the block chooses the earliest write cycle that avoids contention on the data bus. It can cut short the burst the memory continues after the last wanted read. To do this it raises DQM early enough to silence the unwanted trailing words, and then issues the WRITE, whose registration floats the memory's outputs. If the burst has already drained, the write goes out at once with no masking. An optional idle cycle can be required between the last word the memory drives and the WRITE. This covers systems where the controller's driver may turn on before the memory's outputs release.

Top module: `sdram_rw_sched`

## Requirements
- R1: With CAS latency CL programmed as 1, 2 or 3 on `cas_lat`, a READ in cycle c has the word present on `dq_in` during cycle c+CL returned on `rd_data` with `rd_valid` high in cycle c+CL+1, together with the READ's bank and column on `rd_bank`/`rd_col`, in issue order.
- R2: A read request is accepted in every cycle it is presented, so back-to-back read requests produce READ commands in consecutive cycles. Command encoding on `cmd`: 2'b00 NOP, 2'b01 READ, 2'b10 WRITE.
- R3: A write request with no read burst outstanding is issued in the cycle after it is presented. In that cycle `dq_oe` is high and `dq_out` holds its write data, and `dq_oe` is high in no other cycle.
- R4: DQM, which masks the memory's word two cycles later, is never high in a cycle whose masked slot holds a wanted read word, so no requested word is lost.
- R5: A WRITE that truncates a read burst is preceded by DQM high in at least its two previous cycles (three with the gap enabled), and DQM is low in the WRITE cycle itself.
- R6: A write presented in the cycle right after the last READ (cycle c) is issued at cycle c+3 for CL 1 or 2 and c+4 for CL 3, plus one cycle when `gap_en` is high.
- R7: The memory never drives an unmasked word in a cycle where `dq_oe` is high, and with `gap_en` high it drives nothing in the cycle just before a WRITE.
- R8: In the cycle after one with no request presented, `cmd` is NOP and `dqm` and `dq_oe` are low.
- R9: A read presented in the cycle right after a write was accepted is issued in the cycle right after the WRITE.
- R10: During reset `cmd` is NOP and `dqm`, `dq_oe` and `rd_valid` are low.
- R11: A write presented once the memory's full burst (length `BURST_LEN`, plus the gap cycle if enabled) has ended is issued in the next cycle without any DQM cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cas_lat | input | 2 | CAS latency, 1 to 3 (0 treated as 1); changed only while idle |
| gap_en | input | 1 | Require one quiet bus cycle before each WRITE |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Request bank |
| req_col | input | COL_W | Request column |
| req_wdata | input | DATA_W | Write data |
| cmd | output | 2 | Column command: 00 NOP, 01 READ, 10 WRITE |
| ba | output | BANK_W | Command bank |
| col_addr | output | COL_W | Command column |
| dqm | output | 1 | Data mask, acts on read output two cycles later |
| dq_oe | output | 1 | Controller data driver enable |
| dq_out | output | DATA_W | Write data driven with WRITE |
| dq_in | input | DATA_W | Data bus as seen from the memory |
| rd_valid | output | 1 | Returned read word valid |
| rd_bank | output | BANK_W | Bank of returned word |
| rd_col | output | COL_W | Column of returned word |
| rd_data | output | DATA_W | Returned read word |

## Verification
Reads are sent as single requests and as six-deep back-to-back streams at each CAS latency. A burst-continuing memory model sits behind them, so a latency or ordering error shows up as a wrong word, a wrong tag or a wrong return cycle. The read-then-write pattern runs for every latency with the gap off and on. It separates the exact turnaround cycle, the DQM lead, and the bus-collision and quiet-cycle rules. Those rules depend on how CL and the gap interact. A write presented just as the burst ends shows whether masking is skipped when it is not needed. Write-then-read and idle stretches check that no turnaround is added in the other direction and that the outputs stay quiet.

// File: rtl/sdram_rw_sched.sv
module sdram_rw_sched #(
  parameter int DATA_W    = 16,
  parameter int COL_W     = 10,
  parameter int BANK_W    = 2,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cas_lat,
  input  logic              gap_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [1:0]        cmd,
  output logic [BANK_W-1:0] ba,
  output logic [COL_W-1:0]  col_addr,
  output logic              dqm,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_out,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [BANK_W-1:0] rd_bank,
  output logic [COL_W-1:0]  rd_col,
  output logic [DATA_W-1:0] rd_data
);

  localparam logic [1:0] CMD_NOP = 2'd0;
  localparam logic [1:0] CMD_RD  = 2'd1;
  localparam logic [1:0] CMD_WR  = 2'd2;
  localparam int AGE_W   = $clog2(BURST_LEN + 8) + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;
  localparam int PIPE    = 3;
  localparam int TAG_W   = BANK_W + COL_W;

  logic [1:0]       cl_eff;
  logic [AGE_W-1:0] age, age_inc, lat, gap, mask_from;
  logic [1:0]       dqm_run, need_run;
  logic             busy_next, wr_ok, issue_rd, issue_wr, dqm_nxt, capture;
  logic [PIPE-1:0]  pipe_v;
  logic [TAG_W-1:0] pipe_tag [PIPE];

  assign cl_eff    = (cas_lat == 2'd0) ? 2'd1 : cas_lat;
  assign lat       = AGE_W'(cl_eff);
  assign gap       = AGE_W'(gap_en);
  assign age_inc   = (age == AGE_MAX) ? age : age + 1'b1;
  assign mask_from = (lat > 1) ? lat - 1'b1 : AGE_W'(1);
  assign need_run  = 2'd2 + {1'b0, gap_en};

  // read burst (or the gap cycle after it) still occupies the bus next cycle
  assign busy_next = age_inc < lat + AGE_W'(BURST_LEN) + gap;
  assign wr_ok     = !busy_next || (age_inc >= lat + 1'b1 + gap && dqm_run >= need_run);

  assign req_ready = !req_write || wr_ok;
  assign issue_rd  = req_valid && !req_write;
  assign issue_wr  = req_valid && req_write && wr_ok;
  assign dqm_nxt   = req_valid && req_write && !wr_ok && busy_next && age_inc >= mask_from;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd      <= CMD_NOP;
      ba       <= '0;
      col_addr <= '0;
      dqm      <= 1'b0;
      dq_oe    <= 1'b0;
      dq_out   <= '0;
      age      <= AGE_MAX;
      dqm_run  <= '0;
    end else begin
      cmd <= issue_rd ? CMD_RD : (issue_wr ? CMD_WR : CMD_NOP);
      if (issue_rd || issue_wr) begin
        ba       <= req_bank;
        col_addr <= req_col;
      end
      dq_oe <= issue_wr;
      if (issue_wr) dq_out <= req_wdata;
      dqm     <= dqm_nxt;
      dqm_run <= dqm_nxt ? ((dqm_run == 2'd3) ? dqm_run : dqm_run + 1'b1) : 2'd0;
      age     <= issue_rd ? '0 : age_inc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe_v[0]   <= 1'b0;
      pipe_tag[0] <= '0;
    end else begin
      pipe_v[0]   <= (cmd == CMD_RD);
      pipe_tag[0] <= {ba, col_addr};
    end
  end

  for (genvar i = 1; i < PIPE; i++) begin : g_ret
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pipe_v[i]   <= 1'b0;
        pipe_tag[i] <= '0;
      end else begin
        pipe_v[i]   <= pipe_v[i-1];
        pipe_tag[i] <= pipe_tag[i-1];
      end
    end
  end

  assign capture = pipe_v[cl_eff - 2'd1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_bank  <= '0;
      rd_col   <= '0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (capture) begin
        {rd_bank, rd_col} <= pipe_tag[cl_eff - 2'd1];
        rd_data           <= dq_in;
      end
    end
  end

  assert_write_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_WR |-> age >= lat + 1'b1 + gap);

  assert_dqm_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_WR && age < lat + AGE_W'(BURST_LEN) + gap) |-> ($past(dqm) && $past(dqm, 2)));

  assert_dqm_low_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_WR |-> !dqm);

  assert_no_mask_wanted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !$past(dqm, 2));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> (cmd == CMD_NOP && !dqm && !dq_oe));

  assert_read_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && !req_write) |-> cmd == CMD_RD);

endmodule

// File: tb/tb_sdram_rw_sched.sv
module tb_sdram_rw_sched;
  localparam int DW = 16, CW = 10, BW = 2, BL = 4;

  logic clk = 0, rst_n = 0;
  logic [1:0] cas_lat = 2'd2;
  logic gap_en = 0;
  logic req_valid = 0, req_ready, req_write = 0;
  logic [BW-1:0] req_bank = '0;
  logic [CW-1:0] req_col = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] cmd;
  logic [BW-1:0] ba, rd_bank;
  logic [CW-1:0] col_addr, rd_col;
  logic dqm, dq_oe, rd_valid;
  logic [DW-1:0] dq_out, dq_in = 16'hDEAD, rd_data;

  sdram_rw_sched #(.DATA_W(DW), .COL_W(CW), .BANK_W(BW), .BURST_LEN(BL)) dut (
    .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat), .gap_en(gap_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bank(req_bank), .req_col(req_col), .req_wdata(req_wdata),
    .cmd(cmd), .ba(ba), .col_addr(col_addr), .dqm(dqm), .dq_oe(dq_oe),
    .dq_out(dq_out), .dq_in(dq_in), .rd_valid(rd_valid), .rd_bank(rd_bank),
    .rd_col(rd_col), .rd_data(rd_data));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, ret_cnt = 0;
  int last_rd = -100, last_wr = -100, wr_run = 0, dqm_obs_run = 0;
  logic wr_oe = 0, wr_dqm = 0;
  logic [DW-1:0] wr_dout = '0;
  logic [BW+CW-1:0] exp_tag [$];
  int exp_time [$];
  bit sv [16];
  logic [DW-1:0] sd [16];
  bit dqm_d1 = 0, dqm_d2 = 0, mem_drv = 0, mem_drv_prev = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] mem_word(logic [BW-1:0] b, logic [CW-1:0] c);
    return DW'(c) * 16'd3 + DW'(b) * 16'd1000 ^ 16'hA5C3;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // memory model with burst continuation and write truncation; bus checks
  always @(negedge clk) if (rst_n) begin
    int cl;
    logic [BW+CW-1:0] t;
    int et;
    cl = (cas_lat == 0) ? 1 : int'(cas_lat);
    if (cmd == 2'd2) for (int k = 0; k < 8; k++) sv[(cyc + k) % 16] = 0;
    mem_drv = sv[cyc % 16] && !dqm_d2;
    dq_in = mem_drv ? sd[cyc % 16] : 16'hDEAD;
    sv[cyc % 16] = 0;
    if (cmd == 2'd1) begin
      for (int k = 0; k < BL; k++) begin
        sv[(cyc + cl + k) % 16] = 1;
        sd[(cyc + cl + k) % 16] = mem_word(ba, col_addr + CW'(k));
      end
      exp_time.push_back(cyc + cl + 1);
      last_rd = cyc;
    end
    if (dq_oe) chk(!mem_drv, "R7", "bus collision", 1, 0);
    if (cmd == 2'd2 && gap_en) chk(!mem_drv_prev, "R7", "memory drove before write", 1, 0);
    chk(dq_oe == (cmd == 2'd2), "R3", "oe only with write", int'(dq_oe), int'(cmd == 2'd2));
    if (cmd == 2'd2) begin
      last_wr = cyc; wr_run = dqm_obs_run; wr_oe = dq_oe; wr_dout = dq_out; wr_dqm = dqm;
    end
    if (rd_valid) begin
      if (exp_tag.size() == 0 || exp_time.size() == 0) chk(0, "R1", "unexpected return", 1, 0);
      else begin
        t = exp_tag.pop_front();
        et = exp_time.pop_front();
        chk(et == cyc, "R1", "return cycle", cyc, et);
        chk({rd_bank, rd_col} == t, "R1", "return tag", int'({rd_bank, rd_col}), int'(t));
        chk(rd_data == mem_word(t[CW+BW-1:CW], t[CW-1:0]), "R4", "return data",
            int'(rd_data), int'(mem_word(t[CW+BW-1:CW], t[CW-1:0])));
        ret_cnt++;
      end
    end
    dqm_obs_run = dqm ? dqm_obs_run + 1 : 0;
    dqm_d2 = dqm_d1; dqm_d1 = dqm; mem_drv_prev = mem_drv;
  end

  task automatic send(bit w, logic [BW-1:0] b, logic [CW-1:0] c, logic [DW-1:0] d, output int acc);
    @(negedge clk);
    req_valid = 1; req_write = w; req_bank = b; req_col = c; req_wdata = d;
    if (!w) exp_tag.push_back({b, c});
    forever begin
      #1;
      if (req_ready) begin
        acc = cyc;
        @(posedge clk);
        #1 req_valid = 0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic wait_until(int n);
    @(negedge clk);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic drain();
    repeat (14) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(cmd == 2'd0, "R10", "cmd in reset", int'(cmd), 0);
    chk(!dqm && !dq_oe, "R10", "dqm/oe in reset", int'({dqm, dq_oe}), 0);
    chk(!rd_valid, "R10", "rd_valid in reset", int'(rd_valid), 0);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(cmd == 2'd0 && !dqm && !dq_oe, "R8", "idle outputs", int'({cmd, dqm, dq_oe}), 0);
    end
  endtask

  task automatic t_read_stream(int cl);
    int a, a0, r0, first_rd;
    cas_lat = 2'(cl); gap_en = 0;
    drain();
    r0 = ret_cnt;
    send(0, 2'd1, 10'd100, '0, a0);
    first_rd = a0 + 1;
    for (int i = 1; i < 6; i++) begin
      send(0, 2'(i), CW'(37 * i + cl), '0, a);
      chk(a == a0 + i, "R2", "read accepted each cycle", a, a0 + i);
    end
    drain();
    chk(last_rd == first_rd + 5, "R2", "consecutive READs", last_rd, first_rd + 5);
    chk(ret_cnt - r0 == 6, "R1", "words returned", ret_cnt - r0, 6);
  endtask

  task automatic t_turn(int cl, bit g);
    int a, r0, exp_gap;
    cas_lat = 2'(cl); gap_en = g;
    drain();
    r0 = ret_cnt;
    send(0, 2'd2, 10'd10, '0, a);
    send(0, 2'd3, 10'd500, '0, a);
    send(0, 2'd0, 10'd7, '0, a);
    send(1, 2'd0, 10'd8, 16'h1234 + DW'(cl), a);
    drain();
    exp_gap = ((cl == 3) ? 4 : 3) + int'(g);
    chk(last_wr - last_rd == exp_gap, "R6", "read-to-write spacing", last_wr - last_rd, exp_gap);
    chk(wr_run >= 2 + int'(g), "R5", "dqm lead cycles", wr_run, 2 + int'(g));
    chk(!wr_dqm, "R5", "dqm in write cycle", int'(wr_dqm), 0);
    chk(wr_oe && wr_dout == 16'h1234 + DW'(cl), "R3", "write data", int'(wr_dout), int'(16'h1234 + DW'(cl)));
    chk(ret_cnt - r0 == 3, "R4", "wanted words kept", ret_cnt - r0, 3);
  endtask

  task automatic t_late_write(int cl, bit g);
    int a, d;
    cas_lat = 2'(cl); gap_en = g;
    drain();
    send(0, 2'd1, 10'd321, '0, a);
    d = a + cl + BL + int'(g);
    wait_until(d - 1);
    send(1, 2'd1, 10'd322, 16'hBEEF, a);
    drain();
    chk(a == d, "R11", "write accepted at once", a, d);
    chk(last_wr == d + 1, "R11", "write cycle", last_wr, d + 1);
    chk(wr_run == 0, "R11", "no dqm needed", wr_run, 0);
  endtask

  task automatic t_lone_write();
    int a;
    drain();
    send(1, 2'd2, 10'd55, 16'h0F0F, a);
    drain();
    chk(last_wr == a + 1, "R3", "lone write next cycle", last_wr, a + 1);
    chk(wr_dout == 16'h0F0F && wr_run == 0, "R3", "lone write data", int'(wr_dout), 16'h0F0F);
  endtask

  task automatic t_write_then_read(int cl);
    int aw, ar;
    cas_lat = 2'(cl); gap_en = 1;
    drain();
    send(1, 2'd3, 10'd9, 16'h7777, aw);
    send(0, 2'd3, 10'd9, '0, ar);
    drain();
    chk(ar == aw + 1, "R9", "read accepted after write", ar, aw + 1);
    chk(last_rd == last_wr + 1, "R9", "read right after write", last_rd, last_wr + 1);
  endtask

  initial begin
    t_reset();
    @(negedge clk) rst_n = 1;
    t_idle();
    for (int cl = 1; cl <= 3; cl++) t_read_stream(cl);
    for (int cl = 1; cl <= 3; cl++) begin
      t_turn(cl, 0);
      t_turn(cl, 1);
    end
    t_late_write(2, 0);
    t_late_write(3, 1);
    t_lone_write();
    t_write_then_read(1);
    t_write_then_read(3);
    t_idle();
    chk(exp_tag.size() == 0, "R4", "no outstanding reads lost", exp_tag.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog expired: actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule